// File: doc/BRIEF.md
# Linked-Descriptor Page Table Refill Engine

This block is a bus-master engine that loads entries of a two-dimensional page address table. It takes its work from a chain of descriptors held in memory. Each descriptor names an inclusive rectangle of table slots, a table number, an enable flag, the location of an array of 32-bit page addresses, and the address of the next descriptor. The engine fetches each page address over a simple one-outstanding memory read port. It then writes the address into the table over a dedicated write port, row by row across the rectangle.

Software first writes zero to the descriptor register to drop any earlier work. It waits until the status register shows ready, then writes the address of the first descriptor. The engine follows the chain until it reaches a next pointer of zero. It then flags list completion in its 8-bit interrupt lane. Faults in a descriptor stop the chain, raise an error flag and return the engine to ready. Interrupt flags are cleared by writing ones. A read-only info register reports how many engines and tables exist.

Top module: `ptab_refill`

## Requirements
- R1: After reset the status register (select 1) reads ready (bit 0) = 1 and error (bit 1) = 0. The interrupt status (select 2) reads 0, the interrupt enable (select 3) reads 0x7E, and `irq` is low.
- R2: The info register (select 4) reports the engine count in bits [28:24] and the table count in bits [20:16], with all other bits zero.
- R3: A write of a nonzero, 16-byte-aligned address to the descriptor register (select 0) while the engine is ready starts the chain at that address, and ready drops.
- R4: A descriptor is four 32-bit words at offsets 0, 4, 8 and 12, as follows:
  - offset 0: the next pointer;
  - offset 4: the corners, with x0 in bits [7:0], y0 in [15:8], x1 in [23:16] and y1 in [31:24];
  - offset 8: the control word, with an enable in bit 0 and the table number in bits [7:4];
  - offset 12: the data pointer.
  For an enabled descriptor the engine makes one table write per slot of the inclusive rectangle, x fastest and then y. The data for each write is taken from consecutive words starting at the data pointer.
- R5: Descriptors are processed strictly in chain order, and a next pointer of zero ends the chain, after which the engine is ready again.
- R6: A descriptor whose enable bit is 0 produces no table writes, and the chain continues with its successor.
- R7: In the interrupt lane, bit 1 (list done) is set when the chain ends normally, and bit 7 (descriptor filled) is set as each descriptor completes. `irq` is the OR of the status bits that are enabled, so with the reset enable of 0x7E the list-done bit raises `irq` and bit 7 does not.
- R8: Writing the interrupt status register clears exactly the bits written as 1.
- R9: Any of the following sets the error status bit and lane bit 2, stops the chain with no further table writes, and leaves the engine ready:
  - a misaligned start address;
  - a misaligned next pointer;
  - a misaligned data pointer on an enabled descriptor;
  - x1 < x0;
  - y1 < y0.
- R10: Writing zero to the descriptor register cancels any work. In the next cycle the engine is ready with the error bit clear, and no table write follows. A later nonzero start also clears the error bit.
- R11: A nonzero write to the descriptor register while the engine is busy is ignored.
- R12: At most one memory read is outstanding, and each returned data word gives exactly one table write in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 descriptor, 1 status, 2 interrupt status, 3 interrupt enable, 4 info) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory read request, one-cycle pulse |
| mem_addr | output | 32 | Memory read byte address |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |
| tbl_we | output | 1 | Table write strobe |
| tbl_id | output | 4 | Table number |
| tbl_x | output | 8 | Table column |
| tbl_y | output | 8 | Table row |
| tbl_data | output | 32 | Page address written |

## Verification
The in-module assertions watch, on every cycle, the properties that hold cycle by cycle:
- every table write lies inside the current rectangle;
- memory requests never come back to back;
- completion, faults and cancel each leave the engine idle one cycle later;
- a fault is latched into the status and interrupt registers.

Only the bench's scenarios can show that the complete write sequence matches the descriptor chain in content and order. The same holds for skipped descriptors producing nothing, a busy-time start being ignored, and masking keeping the fill flag off the interrupt line.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
  typedef enum logic [2:0] {W_IDLE, W_DREQ, W_DWAIT, W_EVAL, W_PREQ, W_PWAIT} walk_st_t;

  localparam logic [2:0] SEL_DESC  = 3'd0;
  localparam logic [2:0] SEL_STAT  = 3'd1;
  localparam logic [2:0] SEL_ISTAT = 3'd2;
  localparam logic [2:0] SEL_IEN   = 3'd3;
  localparam logic [2:0] SEL_INFO  = 3'd4;

  localparam int LB_DONE = 1;
  localparam int LB_ERR  = 2;
  localparam int LB_FILL = 7;
  localparam logic [7:0] IEN_RESET = 8'h7E;

  function automatic logic aligned16(input logic [31:0] a);
    return a[3:0] == 4'h0;
  endfunction

  function automatic logic rect_bad(input logic [7:0] ax0, input logic [7:0] ay0,
                                    input logic [7:0] ax1, input logic [7:0] ay1);
    return (ax1 < ax0) || (ay1 < ay0);
  endfunction
endpackage

// File: rtl/rfe_walker.sv
module rfe_walker
  import rfe_pkg::*;
#(
  parameter int CW = 8,
  parameter int TW = 4
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [31:0]   start_addr,
  input  logic          cancel,
  output logic          mem_req,
  output logic [31:0]   mem_addr,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          tbl_we,
  output logic [TW-1:0] tbl_id,
  output logic [CW-1:0] tbl_x,
  output logic [CW-1:0] tbl_y,
  output logic [31:0]   tbl_data,
  output logic          busy,
  output logic          ev_fill,
  output logic          ev_done,
  output logic          ev_err
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  walk_st_t st;
  logic [31:0] cur, nxt, dptr, daddr;
  logic [CW-1:0] x0, y0, x1, y1, cx, cy;
  logic go;
  logic [TW-1:0] tid;
  logic [1:0] widx;

  // named internal events
  wire word_in   = (st == W_PWAIT) && mem_rvalid;
  wire last_col  = (cx == x1);
  wire last_row  = (cy == y1);
  wire rect_end  = word_in && last_col && last_row;
  wire desc_bad  = rect_bad(8'(x0), 8'(y0), 8'(x1), 8'(y1)) ||
                   (go && !aligned16(dptr)) || !aligned16(nxt);
  wire eval_skip = (st == W_EVAL) && !desc_bad && !go;
  wire bad_start = (st == W_IDLE) && start && !aligned16(start_addr);

  assign ev_fill  = !cancel && (rect_end || eval_skip);
  assign ev_done  = ev_fill && (nxt == 32'd0);
  assign ev_err   = !cancel && (bad_start || ((st == W_EVAL) && desc_bad));
  assign busy     = (st != W_IDLE);
  assign mem_req  = (st == W_DREQ) || (st == W_PREQ);
  assign mem_addr = (st == W_PREQ) ? daddr : cur + {28'd0, widx, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= W_IDLE; cur <= '0; nxt <= '0; dptr <= '0; daddr <= '0;
      x0 <= '0; y0 <= '0; x1 <= '0; y1 <= '0; cx <= '0; cy <= '0;
      go <= 1'b0; tid <= '0; widx <= '0;
      tbl_we <= 1'b0; tbl_id <= '0; tbl_x <= '0; tbl_y <= '0; tbl_data <= '0;
    end else begin
      tbl_we <= 1'b0;
      if (cancel) begin
        st <= W_IDLE;
      end else begin
        unique case (st)
          W_IDLE: if (start && aligned16(start_addr)) begin
            cur <= start_addr; widx <= 2'd0; st <= W_DREQ;
          end
          W_DREQ: st <= W_DWAIT;
          W_DWAIT: if (mem_rvalid) begin
            case (widx)
              2'd0: nxt <= mem_rdata;
              2'd1: begin
                x0 <= mem_rdata[CW-1:0];    y0 <= mem_rdata[8+:CW];
                x1 <= mem_rdata[16+:CW];    y1 <= mem_rdata[24+:CW];
              end
              2'd2: begin go <= mem_rdata[0]; tid <= mem_rdata[4+:TW]; end
              default: dptr <= mem_rdata;
            endcase
            if (widx == 2'd3) st <= W_EVAL;
            else begin widx <= widx + 2'd1; st <= W_DREQ; end
          end
          W_EVAL: begin
            if (desc_bad) st <= W_IDLE;
            else if (go) begin
              cx <= x0; cy <= y0; daddr <= dptr; st <= W_PREQ;
            end else if (nxt == 32'd0) st <= W_IDLE;
            else begin cur <= nxt; widx <= 2'd0; st <= W_DREQ; end
          end
          W_PREQ: st <= W_PWAIT;
          W_PWAIT: if (mem_rvalid) begin
            tbl_we <= 1'b1; tbl_x <= cx; tbl_y <= cy;
            tbl_data <= mem_rdata; tbl_id <= tid;
            daddr <= daddr + 32'd4;
            if (last_col) begin
              cx <= x0;
              if (last_row) begin
                if (nxt == 32'd0) st <= W_IDLE;
                else begin cur <= nxt; widx <= 2'd0; st <= W_DREQ; end
              end else begin
                cy <= cy + ONE; st <= W_PREQ;
              end
            end else begin
              cx <= cx + ONE; st <= W_PREQ;
            end
          end
          default: st <= W_IDLE;
        endcase
      end
    end
  end

  assert_write_in_rect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> (tbl_x >= x0 && tbl_x <= x1 && tbl_y >= y0 && tbl_y <= y1));
  assert_one_outstanding_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  assert_write_follows_word_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (word_in && !cancel) |=> tbl_we);
  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> !busy);
  assert_err_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |=> !busy);
  assert_cancel_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> (!busy && !tbl_we));
endmodule

// File: rtl/rfe_regs.sv
module rfe_regs
  import rfe_pkg::*;
#(
  parameter int ENGINES = 1,
  parameter int TABLES  = 2
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  input  logic        busy,
  input  logic        ev_fill,
  input  logic        ev_done,
  input  logic        ev_err,
  output logic        start,
  output logic        cancel
);
  localparam int LW = 8 * ENGINES;

  logic [LW-1:0] istat, ien;
  logic          err_flag;

  wire desc_wr = reg_wr && (reg_sel == SEL_DESC);
  assign cancel = desc_wr && (reg_wdata == 32'd0);
  assign start  = desc_wr && (reg_wdata != 32'd0) && !busy;

  logic [LW-1:0] ev_set, ack;
  always_comb begin
    ev_set = '0;
    ev_set[LB_DONE] = ev_done;
    ev_set[LB_ERR]  = ev_err;
    ev_set[LB_FILL] = ev_fill;
    ack = (reg_wr && reg_sel == SEL_ISTAT) ? reg_wdata[LW-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      istat <= '0;
      ien <= {ENGINES{IEN_RESET}};
      err_flag <= 1'b0;
    end else begin
      istat <= (istat & ~ack) | ev_set;
      if (reg_wr && reg_sel == SEL_IEN) ien <= reg_wdata[LW-1:0];
      if (ev_err) err_flag <= 1'b1;
      else if (cancel || start) err_flag <= 1'b0;
    end
  end

  assign irq = |(istat & ien);

  always_comb begin
    case (reg_sel)
      SEL_STAT:  reg_rdata = {30'd0, err_flag, !busy};
      SEL_ISTAT: reg_rdata = 32'(istat);
      SEL_IEN:   reg_rdata = 32'(ien);
      SEL_INFO:  reg_rdata = {3'd0, 5'(ENGINES), 3'd0, 5'(TABLES), 16'd0};
      default:   reg_rdata = 32'd0;
    endcase
  end

  assert_err_latched_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |=> (istat[LB_ERR] && err_flag));
  assert_done_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(istat[LB_DONE]) |-> $past(ev_done));
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_ISTAT && reg_wdata[LB_DONE] && !ev_done) |=> !istat[LB_DONE]);
endmodule

// File: rtl/ptab_refill.sv
module ptab_refill
  import rfe_pkg::*;
#(
  parameter int TABLES = 2,
  parameter int CW     = 8,
  parameter int TW     = 4
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  output logic          mem_req,
  output logic [31:0]   mem_addr,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          tbl_we,
  output logic [TW-1:0] tbl_id,
  output logic [CW-1:0] tbl_x,
  output logic [CW-1:0] tbl_y,
  output logic [31:0]   tbl_data
);
  // coordinates sit in byte lanes of the corner word, so CW <= 8 and TW <= 4
  localparam int ENGINES = 1;

  logic busy, ev_fill, ev_done, ev_err, start, cancel;

  rfe_regs #(.ENGINES(ENGINES), .TABLES(TABLES)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .busy(busy),
    .ev_fill(ev_fill), .ev_done(ev_done), .ev_err(ev_err),
    .start(start), .cancel(cancel)
  );

  rfe_walker #(.CW(CW), .TW(TW)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(reg_wdata),
    .cancel(cancel), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .tbl_we(tbl_we),
    .tbl_id(tbl_id), .tbl_x(tbl_x), .tbl_y(tbl_y), .tbl_data(tbl_data),
    .busy(busy), .ev_fill(ev_fill), .ev_done(ev_done), .ev_err(ev_err)
  );
endmodule

// File: tb/ptab_refill_test.sv
module ptab_refill_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_sel = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic irq, mem_req, mem_rvalid, tbl_we;
  logic [31:0] mem_addr, mem_rdata, tbl_data;
  logic [3:0] tbl_id;
  logic [7:0] tbl_x, tbl_y;

  ptab_refill uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .tbl_we(tbl_we), .tbl_id(tbl_id),
    .tbl_x(tbl_x), .tbl_y(tbl_y), .tbl_data(tbl_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_err = 0;
  logic [31:0] mem [0:1023];
  logic [19:0] exp_pos[$], act_pos[$];
  logic [31:0] exp_dat[$], act_dat[$];
  int pend = 0, overlap = 0;
  logic [31:0] pend_addr = 32'd0;

  // memory model: random latency 1..3 cycles, one outstanding read
  initial begin mem_rvalid = 1'b0; mem_rdata = 32'd0; end
  always @(negedge clk) begin
    int lat;
    mem_rvalid <= 1'b0;
    if (pend > 0) begin
      if (pend == 1) begin mem_rvalid <= 1'b1; mem_rdata <= mem[pend_addr[11:2]]; end
      pend <= pend - 1;
    end
    if (mem_req) begin
      if (pend > 1) overlap <= overlap + 1;
      lat = 1 + int'($urandom % 3);
      pend <= lat; pend_addr <= mem_addr;
    end
    if (tbl_we) begin
      act_pos.push_back({tbl_id, tbl_x, tbl_y});
      act_dat.push_back(tbl_data);
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(logic [2:0] sel, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = 32'd0;
  endtask

  task automatic reg_read(logic [2:0] sel, output logic [31:0] d);
    @(negedge clk); reg_sel = sel; #1 d = reg_rdata;
  endtask

  task automatic wait_ready();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      reg_read(3'd1, s);
      if (s[0]) break;
    end
    repeat (6) @(negedge clk);
  endtask

  // writes a descriptor and its data; queues expected writes if asked
  task automatic add_desc(logic [31:0] a, logic [31:0] nxt, logic [7:0] x0, logic [7:0] y0,
                          logic [7:0] x1, logic [7:0] y1, logic go, logic [3:0] tid,
                          logic [31:0] dp, bit expect_it);
    int k = 0;
    mem[a[11:2]]     = nxt;
    mem[a[11:2] + 1] = {y1, x1, y0, x0};
    mem[a[11:2] + 2] = {24'd0, tid, 3'd0, go};
    mem[a[11:2] + 3] = dp;
    if (x1 >= x0 && y1 >= y0) begin
      for (int y = int'(y0); y <= int'(y1); y++)
        for (int x = int'(x0); x <= int'(x1); x++) begin
          logic [31:0] v = $urandom;
          mem[dp[11:2] + k] = v;
          k++;
          if (go && expect_it) begin
            exp_pos.push_back({tid, 8'(x), 8'(y)});
            exp_dat.push_back(v);
          end
        end
    end
  endtask

  task automatic clear_q();
    exp_pos.delete(); exp_dat.delete(); act_pos.delete(); act_dat.delete();
  endtask

  task automatic cmp_writes(string req);
    int bad = 0;
    chk(req, "write count", act_pos.size(), exp_pos.size());
    for (int i = 0; i < act_pos.size() && i < exp_pos.size(); i++)
      if (act_pos[i] !== exp_pos[i] || act_dat[i] !== exp_dat[i]) bad++;
    chk(req, "write order/content mismatches", bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R5 watchdog expired: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int cnt;
    void'($urandom(32'h5EED_0011));
    for (int i = 0; i < 1024; i++) mem[i] = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_read(3'd1, r); chk("R1", "status", r, 32'h1);
    reg_read(3'd2, r); chk("R1", "irq status", r, 32'h0);
    reg_read(3'd3, r); chk("R1", "irq enable", r, 32'h7E);
    chk("R1", "irq pin", irq, 1'b0);
    // R2 info
    reg_read(3'd4, r); chk("R2", "info", r, 32'h0102_0000);

    // directed: one descriptor, 3x2 at (5,7), table 2
    clear_q();
    add_desc(32'h100, 32'h0, 8'd5, 8'd7, 8'd7, 8'd8, 1'b1, 4'd2, 32'h400, 1'b1);
    reg_write(3'd0, 32'h100);
    reg_read(3'd1, r); chk("R3", "busy after start", r[0], 1'b0);
    wait_ready();
    cmp_writes("R4");
    reg_read(3'd2, r); chk("R7", "done+fill flags", r, 32'h82);
    chk("R7", "irq pin on done", irq, 1'b1);
    reg_write(3'd2, 32'h02);
    reg_read(3'd2, r); chk("R8", "partial ack", r, 32'h80);
    chk("R7", "fill flag masked", irq, 1'b0);
    reg_write(3'd2, 32'h80);
    reg_read(3'd2, r); chk("R8", "full ack", r, 32'h0);

    // directed: skipped descriptor then enabled one
    clear_q();
    add_desc(32'h100, 32'h110, 8'd1, 8'd1, 8'd3, 8'd3, 1'b0, 4'd1, 32'h400, 1'b1);
    add_desc(32'h110, 32'h0, 8'd9, 8'd0, 8'd10, 8'd1, 1'b1, 4'd3, 32'h440, 1'b1);
    reg_write(3'd0, 32'h100);
    wait_ready();
    cmp_writes("R6");
    reg_write(3'd2, 32'hFF);

    // random chains
    for (int t = 0; t < 12; t++) begin
      int nd = 1 + int'($urandom % 3);
      clear_q();
      for (int k = 0; k < nd; k++) begin
        logic [7:0] x0 = 8'($urandom % 200), y0 = 8'($urandom % 100);
        logic [7:0] w = 8'(1 + $urandom % 4), h = 8'(1 + $urandom % 3);
        add_desc(32'h100 + 32'(16*k), (k == nd-1) ? 32'h0 : 32'h100 + 32'(16*(k+1)),
                 x0, y0, x0 + w - 8'd1, y0 + h - 8'd1, ($urandom % 4) != 0,
                 4'($urandom % 4), 32'h400 + 32'(64*k), 1'b1);
      end
      reg_write(3'd0, 32'h100);
      wait_ready();
      cmp_writes("R5");
      reg_read(3'd2, r); chk("R7", "done flag", r[1], 1'b1);
      reg_write(3'd2, 32'hFF);
    end

    // R9: x1 < x0
    clear_q();
    add_desc(32'h100, 32'h0, 8'd5, 8'd0, 8'd3, 8'd0, 1'b1, 4'd0, 32'h400, 1'b0);
    reg_write(3'd0, 32'h100);
    wait_ready();
    cmp_writes("R9");
    reg_read(3'd1, r); chk("R9", "status after bad rect", r, 32'h3);
    reg_read(3'd2, r); chk("R9", "error flag lane", r, 32'h04);
    chk("R9", "irq on error", irq, 1'b1);
    reg_write(3'd2, 32'hFF);

    // R9: misaligned data pointer, after a good descriptor
    clear_q();
    add_desc(32'h100, 32'h110, 8'd0, 8'd0, 8'd1, 8'd0, 1'b1, 4'd1, 32'h400, 1'b1);
    add_desc(32'h110, 32'h120, 8'd0, 8'd1, 8'd1, 8'd1, 1'b1, 4'd1, 32'h444, 1'b0);
    add_desc(32'h120, 32'h0, 8'd0, 8'd2, 8'd1, 8'd2, 1'b1, 4'd1, 32'h480, 1'b0);
    reg_write(3'd0, 32'h100);
    wait_ready();
    cmp_writes("R9");
    reg_read(3'd2, r); chk("R9", "error with one fill", r, 32'h84);
    reg_write(3'd2, 32'hFF);

    // R9: misaligned start address
    clear_q();
    reg_write(3'd0, 32'h108);
    reg_read(3'd1, r); chk("R9", "misaligned start status", r, 32'h3);
    reg_read(3'd2, r); chk("R9", "misaligned start flag", r, 32'h04);
    reg_write(3'd2, 32'hFF);

    // R10: a good start clears error
    clear_q();
    add_desc(32'h100, 32'h0, 8'd2, 8'd2, 8'd2, 8'd2, 1'b1, 4'd0, 32'h400, 1'b1);
    reg_write(3'd0, 32'h100);
    wait_ready();
    reg_read(3'd1, r); chk("R10", "error cleared by start", r, 32'h1);
    cmp_writes("R4");
    reg_write(3'd2, 32'hFF);

    // R10: cancel mid-chain
    clear_q();
    add_desc(32'h100, 32'h0, 8'd0, 8'd0, 8'd7, 8'd7, 1'b1, 4'd1, 32'h800, 1'b0);
    reg_write(3'd0, 32'h100);
    repeat (40) @(negedge clk);
    reg_write(3'd0, 32'h0);
    #1 cnt = act_pos.size();
    reg_read(3'd1, r); chk("R10", "ready after cancel", r, 32'h1);
    repeat (20) @(negedge clk);
    chk("R10", "no writes after cancel", act_pos.size(), cnt);
    chk("R10", "some writes before cancel", cnt > 0 && cnt < 64, 1'b1);
    reg_read(3'd2, r); chk("R10", "no done after cancel", r[1], 1'b0);
    reg_write(3'd2, 32'hFF);

    // R11: start while busy ignored
    clear_q();
    add_desc(32'h100, 32'h0, 8'd20, 8'd4, 8'd21, 8'd6, 1'b1, 4'd2, 32'h400, 1'b1);
    add_desc(32'h140, 32'h0, 8'd50, 8'd50, 8'd51, 8'd50, 1'b1, 4'd3, 32'h500, 1'b0);
    reg_write(3'd0, 32'h100);
    repeat (3) @(negedge clk);
    reg_write(3'd0, 32'h140);
    wait_ready();
    cmp_writes("R11");

    chk("R12", "overlapping memory requests", overlap, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule